// File: doc/BRIEF.md
# Headphone and Speaker Volume Target Selector

This block converts three digitised control levels into the target step of a 32-step audio gain stage. The levels are a master volume, a headphone reduction and a headphone ceiling. Each arrives as an unsigned per-mille code, where 0 means none of the reference and 1000 means all of it. A mode input chooses between speaker (bridged) behaviour and headphone (single-ended) behaviour. The block registers the resulting step index together with a mute flag. A separate ramp stage walks the analog gain toward that step.

Step 0 is mute. Step 1 corresponds to -40 dB on the speaker path, and each higher step adds 2.53 dB, so step 31 is +36 dB. The headphone path applies the same step 6 dB lower, which gives a range of -46 dB to +30 dB. A headphone result below the lowest audible step therefore lands on step 0. The block does not compute the decibel values. It produces only the step index, and the analog stage supplies the gain and the headphone offset.

In headphone mode the reduction is subtracted from the master level, and the subtraction stops at zero. The smaller of that difference and the ceiling is then taken. This minimum is formed on the raw per-mille levels before quantisation, so rounding at the step boundaries happens once and only once.

Top module: `vol_target_sel`

## Requirements
- R1: A per-mille level is quantised to a step equal to the number of boundaries it reaches or exceeds. The boundaries are 100, 126, 152, 180, 206, 234, 260, 286, 314, 340, 366, 394, 420, 446, 472, 500, 526, 554, 580, 606, 634, 660, 686, 714, 740, 766, 794, 820, 846, 874 and 900. A level equal to a boundary takes the higher step.
- R2: A level from 0 to 99 gives step 0. A level of 900 or more gives step 31.
- R3: With `hp_mode` = 0 (speaker), the step depends on `vol_lvl` alone. `diff_lvl` and `ceil_lvl` have no effect.
- R4: With `hp_mode` = 1 (headphone), the quantised level is min(`vol_lvl` - `diff_lvl`, `ceil_lvl`). This minimum is formed on the per-mille codes before quantisation.
- R5: The headphone subtraction saturates at 0 and never wraps. When `diff_lvl` >= `vol_lvl`, the headphone step is 0.
- R6: In headphone mode, a ceiling below 100 gives step 0 whatever the other levels are. A ceiling of 1000 lets the saturated difference through unchanged.
- R7: `mute` is 1 exactly when `target_step` is 0.
- R8: Outputs are registered. A change on the inputs appears after the next rising clock edge and not before it. While `rst_n` is low, `target_step` is 0 and `mute` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_mode | input | 1 | 1 selects headphone mode, 0 selects speaker mode |
| vol_lvl | input | 10 | Master volume level, per-mille code |
| diff_lvl | input | 10 | Headphone reduction level, per-mille code |
| ceil_lvl | input | 10 | Headphone ceiling level, per-mille code |
| target_step | output | 5 | Registered target step, 0 to 31 |
| mute | output | 1 | Registered flag, high when the target step is 0 |

## Verification
The hardest case to reach from the ports is one where taking the minimum before quantisation gives a different step from quantising each level on its own. Uniform random levels almost never land close enough to a boundary to show the difference. The stimulus therefore includes a directed headphone case in which the master level lies just above one boundary and a small reduction pulls it below that boundary. It also walks every boundary and the code one below it in both modes. Random vectors then cover the ceiling and saturation regions and the mode switching.

// File: rtl/vtsel_pkg.sv
package vtsel_pkg;
  localparam int LVL_W     = 10;
  localparam int NUM_STEPS = 32;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int NUM_BOUND = NUM_STEPS - 1;

  // Lower edge of steps 1..31, per-mille of the reference, strictly increasing
  localparam logic [LVL_W-1:0] STEP_EDGE [0:NUM_BOUND-1] = '{
    10'd100, 10'd126, 10'd152, 10'd180, 10'd206, 10'd234, 10'd260, 10'd286,
    10'd314, 10'd340, 10'd366, 10'd394, 10'd420, 10'd446, 10'd472, 10'd500,
    10'd526, 10'd554, 10'd580, 10'd606, 10'd634, 10'd660, 10'd686, 10'd714,
    10'd740, 10'd766, 10'd794, 10'd820, 10'd846, 10'd874, 10'd900
  };
endpackage

// File: rtl/vtsel_lvl_combine.sv
module vtsel_lvl_combine
  import vtsel_pkg::*;
#(
  parameter int W = LVL_W
) (
  input  logic         hp_mode,
  input  logic [W-1:0] vol_lvl,
  input  logic [W-1:0] diff_lvl,
  input  logic [W-1:0] ceil_lvl,
  output logic [W-1:0] eff_lvl
);
  logic [W-1:0] reduced;
  logic [W-1:0] hp_lvl;

  always_comb begin
    // saturating subtraction: never wraps below zero
    reduced = (vol_lvl > diff_lvl) ? (vol_lvl - diff_lvl) : '0;
    hp_lvl  = (reduced < ceil_lvl) ? reduced : ceil_lvl;
    eff_lvl = hp_mode ? hp_lvl : vol_lvl;
  end
endmodule

// File: rtl/vtsel_quantize.sv
module vtsel_quantize
  import vtsel_pkg::*;
#(
  parameter int W  = LVL_W,
  parameter int SW = STEP_W,
  parameter int NB = NUM_BOUND
) (
  input  logic [W-1:0]  lvl,
  output logic [SW-1:0] step
);
  logic [NB-1:0] reached;

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign reached[i] = (lvl >= STEP_EDGE[i]);
  end

  always_comb begin
    step = '0;
    for (int i = 0; i < NB; i++) begin
      step = step + {{(SW-1){1'b0}}, reached[i]};
    end
  end
endmodule

// File: rtl/vol_target_sel.sv
module vol_target_sel
  import vtsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_mode,
  input  logic [LVL_W-1:0]  vol_lvl,
  input  logic [LVL_W-1:0]  diff_lvl,
  input  logic [LVL_W-1:0]  ceil_lvl,
  output logic [STEP_W-1:0] target_step,
  output logic              mute
);
  logic [LVL_W-1:0]  eff_lvl;
  logic [STEP_W-1:0] step_d;
  logic [STEP_W-1:0] step_q;
  logic              mute_d;
  logic              mute_q;

  vtsel_lvl_combine #(.W(LVL_W)) u_combine (
    .hp_mode  (hp_mode),
    .vol_lvl  (vol_lvl),
    .diff_lvl (diff_lvl),
    .ceil_lvl (ceil_lvl),
    .eff_lvl  (eff_lvl)
  );

  vtsel_quantize #(.W(LVL_W), .SW(STEP_W), .NB(NUM_BOUND)) u_quant (
    .lvl  (eff_lvl),
    .step (step_d)
  );

  always_comb begin
    mute_d = (step_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      mute_q <= 1'b1;
    end else begin
      step_q <= step_d;
      mute_q <= mute_d;
    end
  end

  assign target_step = step_q;
  assign mute        = mute_q;
endmodule

// File: rtl/vtsel_checks.sv
module vtsel_checks
  import vtsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hp_mode,
  input logic [LVL_W-1:0]  vol_lvl,
  input logic [LVL_W-1:0]  diff_lvl,
  input logic [LVL_W-1:0]  ceil_lvl,
  input logic [STEP_W-1:0] target_step,
  input logic              mute
);
  AST_MUTE_TRACKS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mute == (target_step == '0)); // R7

  AST_LOW_LEVEL_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_lvl < 10'd100) |=> (target_step == '0)); // R2

  AST_SPK_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_mode && vol_lvl >= 10'd900) |=> (target_step == 5'd31)); // R3

  AST_SUB_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_mode && diff_lvl >= vol_lvl) |=> mute); // R5

  AST_CEIL_ZERO_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_mode && ceil_lvl < 10'd100) |=> mute); // R6

  AST_HOLD_ON_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(hp_mode) && $stable(vol_lvl) && $stable(diff_lvl) && $stable(ceil_lvl))
      |=> $stable(target_step)); // R8
endmodule

bind vol_target_sel vtsel_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hp_mode     (hp_mode),
  .vol_lvl     (vol_lvl),
  .diff_lvl    (diff_lvl),
  .ceil_lvl    (ceil_lvl),
  .target_step (target_step),
  .mute        (mute)
);

// File: tb/vol_target_sel_tb.sv
`timescale 1ns/1ps
module vol_target_sel_tb;
  logic       clk;
  logic       rst_n;
  logic       hp_mode;
  logic [9:0] vol_lvl;
  logic [9:0] diff_lvl;
  logic [9:0] ceil_lvl;
  logic [4:0] target_step;
  logic       mute;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  vol_target_sel u_dut (
    .clk(clk), .rst_n(rst_n), .hp_mode(hp_mode), .vol_lvl(vol_lvl),
    .diff_lvl(diff_lvl), .ceil_lvl(ceil_lvl), .target_step(target_step), .mute(mute)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // boundaries restated from the requirement list
  function automatic int edge_at(input int i);
    int e [31] = '{100,126,152,180,206,234,260,286,314,340,366,394,420,446,472,
                   500,526,554,580,606,634,660,686,714,740,766,794,820,846,874,900};
    return e[i];
  endfunction

  function automatic int quant(input int lvl);
    int s = 0;
    for (int i = 0; i < 31; i++) if (lvl >= edge_at(i)) s++;
    return s;
  endfunction

  function automatic int expect_step(input bit hp, input int v, input int d, input int c);
    int r;
    if (!hp) return quant(v);
    r = (v > d) ? v - d : 0;
    if (c < r) r = c;
    return quant(r);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input bit hp, input int v, input int d, input int c);
    int e;
    @(negedge clk);
    hp_mode = hp; vol_lvl = 10'(v); diff_lvl = 10'(d); ceil_lvl = 10'(c);
    @(negedge clk);
    e = expect_step(hp, v, d, c);
    check(req, int'(target_step), e);
    check("R7", int'(mute), (e == 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e_old;
    void'($urandom(32'd4711));
    rst_n = 1'b0; hp_mode = 1'b0; vol_lvl = '0; diff_lvl = '0; ceil_lvl = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", int'(target_step), 0);
    check("R8", int'(mute), 1);
    rst_n = 1'b1;

    // R1 every boundary and the code below it, speaker mode
    for (int i = 0; i < 31; i++) begin
      apply("R1", 1'b0, edge_at(i), 0, 0);
      apply("R1", 1'b0, edge_at(i) - 1, 0, 0);
    end
    // R2 ends of the range
    apply("R2", 1'b0, 0, 0, 0);
    apply("R2", 1'b0, 99, 0, 0);
    apply("R2", 1'b0, 900, 0, 0);
    apply("R2", 1'b0, 1000, 0, 0);
    // R3 speaker ignores diff and ceil
    apply("R3", 1'b0, 600, 1000, 0);
    apply("R3", 1'b0, 1000, 900, 50);
    check("R3", int'(target_step), 31);
    // R4 minimum before quantisation: 130-27=103 gives step 1 (not 2)
    apply("R4", 1'b1, 130, 27, 1000);
    check("R4", int'(target_step), 1);
    apply("R4", 1'b1, 1000, 400, 1000);
    check("R4", int'(target_step), 19);
    apply("R4", 1'b1, 1000, 0, 600);
    // R5 saturation
    apply("R5", 1'b1, 200, 500, 1000);
    apply("R5", 1'b1, 0, 1000, 1000);
    apply("R5", 1'b1, 300, 300, 1000);
    // R6 ceiling ends
    apply("R6", 1'b1, 1000, 0, 0);
    apply("R6", 1'b1, 1000, 0, 99);
    apply("R6", 1'b1, 800, 100, 1000);
    // R8 latency: value must not change before the edge
    @(negedge clk);
    e_old = int'(target_step);
    hp_mode = 1'b0; vol_lvl = 10'd1000;
    #1;
    check("R8", int'(target_step), e_old);
    @(negedge clk);
    check("R8", int'(target_step), 31);

    // random vectors
    for (int n = 0; n < 2000; n++) begin
      apply("R4", 1'($urandom_range(0, 1)), int'($urandom_range(0, 1000)),
            int'($urandom_range(0, 1000)), int'($urandom_range(0, 1000)));
    end
    // random near-boundary headphone vectors
    for (int n = 0; n < 300; n++) begin
      int b = edge_at(int'($urandom_range(0, 30)));
      apply("R4", 1'b1, b + int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            b + int'($urandom_range(0, 99)) - 2);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule